// File: doc/BRIEF.md
# Key-Guarded Register Bank

This block is a small bank of configuration and scratch registers that software can change only after opening a two-word lock. Two key registers sit at fixed offsets. Only while the first holds 0x83E70B13 and the second holds 0x95A4F1E0 do writes to the guarded registers (three 32-bit scratch words, an interrupt-enable byte and the status flags) take effect. A guarded write made while the bank is locked is dropped without any indication. The usual sequence is: write both keys, change the registers, then write zero to both keys to close the bank again.

The status register holds two sticky flags. Each is set by a one-cycle input pulse and cleared by writing one to its bit. Reads do not depend on the lock state. The read port is combinational and returns the aligned word at the presented address. The bus has one write strobe and a size select that chooses between a byte write (data on bits 7:0, lane taken from address bits 1:0) and a 32-bit word write.

Top module: `kick_guard_regs`

## Requirements
- R1: After reset, every register reads as zero (both keys, the three scratch words, the interrupt-enable byte and both status flags), and the bank is locked.
- R2: The key registers at 0x6C and 0x70 accept any aligned word write in any lock state and read back what was written. The bank is unlocked exactly while 0x6C holds 0x83E70B13 and 0x70 holds 0x95A4F1E0.
- R3: One correct key alone leaves the bank locked. A wrong value written to either key locks it again, and writing zero to both keys locks it.
- R4: While the bank is locked, a write to a scratch word, to the interrupt-enable register or to the status register leaves that register unchanged.
- R5: Scratch words at 0x60, 0x64 and 0x68 take aligned 32-bit word writes while the bank is unlocked. Byte writes and word writes with nonzero address bits 1:0 leave them unchanged.
- R6: Writes at 0x6C and above never reach scratch storage. Unmapped word addresses (for example 0x74) read as zero and ignore writes.
- R7: The interrupt-enable register at 0x48 is 8 bits wide and reads in bits 7:0. It is loaded from data bits 7:0 by an unlocked word write or by a byte write to lane 0. Byte writes to other lanes do not change it, and writing zero clears it.
- R8: Status at 0x44 reads the alarm flag in bit 6 and the second-alarm/power-up flag in bit 7, with all other bits zero. A one-cycle alarm pulse sets bit 6 and a wake pulse sets bit 7 on the next clock edge.
- R9: An unlocked write to 0x44, either a lane-0 byte write or a word write, clears each flag whose bit (7 or 6) in the data is one. Zero bits leave the flags unchanged.
- R10: When a set pulse and a clearing write act on the same flag in the same cycle, the flag ends up set.
- R11: Reads work in every lock state: the read data always equals the current contents of the aligned word at the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte address for read and write |
| busWrite | input | 1 | Write strobe, one transfer per cycle |
| busByte | input | 1 | 1: byte write from bits 7:0, 0: 32-bit word write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for the aligned word at busAddr |
| alarmPulse | input | 1 | Sets status bit 6 |
| wakePulse | input | 1 | Sets status bit 7 |

## Verification
The case that is hardest to reach from the ports is a set pulse that arrives in the same cycle as a clearing write, while the bank is unlocked. The stimulus first writes both keys, then raises the pulse in the very cycle the write-one-to-clear word is presented. It also walks through the partial-lock states: one key correct, then a wrong second key, then a zero relock. In each state it attempts guarded writes and reads the target registers back, and a behavioural model of the whole bank is compared with the read port on every clock.

// File: rtl/kick_guard_pkg.sv
`timescale 1ns/1ps
package kick_guard_pkg;
  localparam logic [31:0] UNLOCK_KEY_A = 32'h83E7_0B13;
  localparam logic [31:0] UNLOCK_KEY_B = 32'h95A4_F1E0;
  localparam int IDX_W = 4;            // up to 16 scratch words
  localparam int ALARM_BIT = 6;
  localparam int WAKE_BIT  = 7;

  typedef struct packed {
    logic             keyAWr;
    logic             keyBWr;
    logic             scratchWr;
    logic [IDX_W-1:0] scratchIdx;
    logic             intEnWr;
    logic             statusWr;
  } wrStrobes_t;
endpackage

// File: rtl/kick_guard_ctrl.sv
`timescale 1ns/1ps
module kick_guard_ctrl
  import kick_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_SCRATCH = 3,
  parameter logic [ADDR_W-1:0] SCRATCH_BASE = 8'h60,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h44,
  parameter logic [ADDR_W-1:0] INTEN_ADDR = 8'h48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busByte,
  input  logic              kickOk,
  output wrStrobes_t        strb
);
  localparam logic [ADDR_W-1:0] KEYA_ADDR = SCRATCH_BASE + ADDR_W'(4 * NUM_SCRATCH);
  localparam logic [ADDR_W-1:0] KEYB_ADDR = KEYA_ADDR + ADDR_W'(4);

  logic aligned;
  logic wordWr;
  logic lane0Wr;
  logic inScratch;
  logic [ADDR_W-1:0] scrOffset;

  assign aligned   = (busAddr[1:0] == 2'b00);
  assign wordWr    = busWrite && !busByte && aligned;
  assign lane0Wr   = busWrite && busByte && aligned;
  assign scrOffset = busAddr - SCRATCH_BASE;
  assign inScratch = (busAddr >= SCRATCH_BASE) && (busAddr < KEYA_ADDR);

  always_comb begin
    strb = '0;
    strb.keyAWr     = wordWr && (busAddr == KEYA_ADDR);
    strb.keyBWr     = wordWr && (busAddr == KEYB_ADDR);
    strb.scratchWr  = wordWr && inScratch && kickOk;
    strb.scratchIdx = IDX_W'(scrOffset >> 2);
    strb.intEnWr    = (wordWr || lane0Wr) && (busAddr == INTEN_ADDR) && kickOk;
    strb.statusWr   = (wordWr || lane0Wr) && (busAddr == STATUS_ADDR) && kickOk;
  end

  AST_LOCKED_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !kickOk |-> !(strb.scratchWr || strb.intEnWr || strb.statusWr)); // R4
  AST_KEY_ALWAYS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !busByte && busAddr == KEYA_ADDR) |-> strb.keyAWr); // R2
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.keyAWr, strb.keyBWr, strb.scratchWr, strb.intEnWr, strb.statusWr})); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |-> !(strb.keyAWr || strb.keyBWr || strb.scratchWr)); // R5
endmodule

// File: rtl/kick_guard_datapath.sv
`timescale 1ns/1ps
module kick_guard_datapath
  import kick_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_SCRATCH = 3,
  parameter int INTEN_W = 8,
  parameter logic [ADDR_W-1:0] SCRATCH_BASE = 8'h60,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h44,
  parameter logic [ADDR_W-1:0] INTEN_ADDR = 8'h48
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              alarmPulse,
  input  logic              wakePulse,
  output logic              kickOk,
  output logic [31:0]       busRdata
);
  localparam logic [ADDR_W-1:0] KEYA_ADDR = SCRATCH_BASE + ADDR_W'(4 * NUM_SCRATCH);
  localparam logic [ADDR_W-1:0] KEYB_ADDR = KEYA_ADDR + ADDR_W'(4);

  logic [31:0]        keyA;
  logic [31:0]        keyB;
  logic [31:0]        scratch [NUM_SCRATCH];
  logic [INTEN_W-1:0] intEn;
  logic               alarmFlag;
  logic               wakeFlag;
  logic [ADDR_W-1:0]  rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyA <= '0;
      keyB <= '0;
    end else begin
      if (strb.keyAWr) keyA <= busWdata;
      if (strb.keyBWr) keyB <= busWdata;
    end
  end

  assign kickOk = (keyA == UNLOCK_KEY_A) && (keyB == UNLOCK_KEY_B);

  for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_scratch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) scratch[i] <= '0;
      else if (strb.scratchWr && strb.scratchIdx == IDX_W'(i)) scratch[i] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intEn <= '0;
    else if (strb.intEnWr) intEn <= busWdata[INTEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      wakeFlag  <= 1'b0;
    end else begin
      alarmFlag <= (alarmFlag && !(strb.statusWr && busWdata[ALARM_BIT])) || alarmPulse;
      wakeFlag  <= (wakeFlag && !(strb.statusWr && busWdata[WAKE_BIT])) || wakePulse;
    end
  end

  assign rdWord = {busAddr[ADDR_W-1:2], 2'b00};

  always_comb begin
    busRdata = '0;
    if (rdWord == STATUS_ADDR) begin
      busRdata[ALARM_BIT] = alarmFlag;
      busRdata[WAKE_BIT]  = wakeFlag;
    end else if (rdWord == INTEN_ADDR) begin
      busRdata[INTEN_W-1:0] = intEn;
    end else if (rdWord == KEYA_ADDR) begin
      busRdata = keyA;
    end else if (rdWord == KEYB_ADDR) begin
      busRdata = keyB;
    end else begin
      for (int i = 0; i < NUM_SCRATCH; i++) begin
        if (rdWord == SCRATCH_BASE + ADDR_W'(4 * i)) busRdata = scratch[i];
      end
    end
  end

  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    alarmPulse |=> alarmFlag); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wakePulse && strb.statusWr && busWdata[WAKE_BIT]) |=> wakeFlag); // R10
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmPulse && !alarmFlag) |=> !alarmFlag); // R8
  AST_LOCKED_INTEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !kickOk |=> $stable(intEn)); // R4
endmodule

// File: rtl/kick_guard_regs.sv
`timescale 1ns/1ps
module kick_guard_regs
  import kick_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_SCRATCH = 3,
  parameter int INTEN_W = 8,
  parameter logic [ADDR_W-1:0] SCRATCH_BASE = 8'h60,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h44,
  parameter logic [ADDR_W-1:0] INTEN_ADDR = 8'h48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busByte,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              alarmPulse,
  input  logic              wakePulse
);
  wrStrobes_t strb;
  logic       kickOk;

  kick_guard_ctrl #(
    .ADDR_W(ADDR_W), .NUM_SCRATCH(NUM_SCRATCH), .SCRATCH_BASE(SCRATCH_BASE),
    .STATUS_ADDR(STATUS_ADDR), .INTEN_ADDR(INTEN_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busByte(busByte), .kickOk(kickOk), .strb(strb)
  );

  kick_guard_datapath #(
    .ADDR_W(ADDR_W), .NUM_SCRATCH(NUM_SCRATCH), .INTEN_W(INTEN_W),
    .SCRATCH_BASE(SCRATCH_BASE), .STATUS_ADDR(STATUS_ADDR), .INTEN_ADDR(INTEN_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWdata(busWdata),
    .alarmPulse(alarmPulse), .wakePulse(wakePulse), .kickOk(kickOk), .busRdata(busRdata)
  );
endmodule

// File: tb/kick_guard_regs_test.sv
`timescale 1ns/1ps
module kick_guard_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic        busByte = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        alarmPulse = 1'b0;
  logic        wakePulse = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit modelLive = 0;

  // behavioural reference state
  logic [31:0] mKeyA, mKeyB, mInt;
  logic [31:0] mScr [3];
  bit mAlarm, mWake;

  always #2.5 clk = ~clk;

  kick_guard_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite), .busByte(busByte),
    .busWdata(busWdata), .busRdata(busRdata), .alarmPulse(alarmPulse), .wakePulse(wakePulse)
  );

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    logic [7:0] w;
    w = {a[7:2], 2'b00};
    case (w)
      8'h44: return {24'h0, mWake, mAlarm, 6'h0};
      8'h48: return mInt;
      8'h60: return mScr[0];
      8'h64: return mScr[1];
      8'h68: return mScr[2];
      8'h6C: return mKeyA;
      8'h70: return mKeyB;
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelReset();
    mKeyA = 0; mKeyB = 0; mInt = 0; mAlarm = 0; mWake = 0;
    for (int i = 0; i < 3; i++) mScr[i] = 0;
  endtask

  task automatic modelStep(input bit wr, input logic [7:0] a, input bit isByte,
                           input logic [31:0] d, input bit pa, input bit pw);
    bit open;
    open = (mKeyA == 32'h83E70B13) && (mKeyB == 32'h95A4F1E0);
    if (wr && a[1:0] == 2'b00) begin
      if (!isByte) begin
        if (a == 8'h6C) mKeyA = d;
        if (a == 8'h70) mKeyB = d;
        if (open && a >= 8'h60 && a < 8'h6C) mScr[(a - 8'h60) >> 2] = d;
      end
      if (open && a == 8'h48) mInt = {24'h0, d[7:0]};
      if (open && a == 8'h44) begin
        if (d[6]) mAlarm = 0;
        if (d[7]) mWake = 0;
      end
    end
    if (pa) mAlarm = 1;
    if (pw) mWake = 1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // continuous comparison of the read port against the model (R11)
  always begin
    @(negedge clk);
    #1;
    if (modelLive && !done) check("R11 per-cycle read", busRdata, modelRead(busAddr));
  end

  task automatic cyc(input bit wr, input logic [7:0] a, input bit isByte,
                     input logic [31:0] d, input bit pa, input bit pw);
    @(negedge clk);
    busWrite = wr; busAddr = a; busByte = isByte; busWdata = d;
    alarmPulse = pa; wakePulse = pw;
    @(posedge clk);
    modelStep(wr, a, isByte, d, pa, pw);
    @(negedge clk);
    busWrite = 0; alarmPulse = 0; wakePulse = 0;
  endtask

  task automatic wrW(input logic [7:0] a, input logic [31:0] d);
    cyc(1, a, 0, d, 0, 0);
  endtask

  task automatic wrB(input logic [7:0] a, input logic [7:0] d);
    cyc(1, a, 1, {24'h0, d}, 0, 0);
  endtask

  task automatic expectRd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a; busWrite = 0;
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic unlock();
    wrW(8'h6C, 32'h83E70B13);
    wrW(8'h70, 32'h95A4F1E0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    modelLive = 1;

    // R1 reset state
    expectRd("R1 status", 8'h44, 32'h0);
    expectRd("R1 inten", 8'h48, 32'h0);
    expectRd("R1 scratch0", 8'h60, 32'h0);
    expectRd("R1 keyA", 8'h6C, 32'h0);

    // R4 locked writes dropped
    wrW(8'h60, 32'h0000_1234);
    expectRd("R4 scratch locked", 8'h60, 32'h0);
    wrW(8'h48, 32'hFF);
    expectRd("R4 inten locked", 8'h48, 32'h0);

    // R8 flags set by pulses
    cyc(0, 8'h00, 0, 0, 1, 0);
    expectRd("R8 alarm bit6", 8'h44, 32'h40);
    cyc(0, 8'h00, 0, 0, 0, 1);
    expectRd("R8 wake bit7", 8'h44, 32'hC0);
    wrW(8'h44, 32'hC0);
    expectRd("R4 status clear locked", 8'h44, 32'hC0);

    // R3 one key only
    wrW(8'h6C, 32'h83E70B13);
    expectRd("R2 keyA readback", 8'h6C, 32'h83E70B13);
    wrW(8'h60, 32'h5555_AAAA);
    expectRd("R3 one key locked", 8'h60, 32'h0);

    // R2 / R5 unlocked scratch
    wrW(8'h70, 32'h95A4F1E0);
    expectRd("R2 keyB readback", 8'h70, 32'h95A4F1E0);
    wrW(8'h60, 32'hDEADBEEF);
    wrW(8'h64, 32'h0BAD_F00D);
    wrW(8'h68, 32'h1357_9BDF);
    expectRd("R5 scratch0", 8'h60, 32'hDEADBEEF);
    expectRd("R5 scratch1", 8'h64, 32'h0BADF00D);
    expectRd("R5 scratch2", 8'h68, 32'h13579BDF);
    wrB(8'h64, 8'h77);
    expectRd("R5 byte write ignored", 8'h64, 32'h0BADF00D);
    wrW(8'h61, 32'hFFFF_FFFF);
    expectRd("R5 misaligned ignored", 8'h60, 32'hDEADBEEF);

    // R6 no aliasing above scratch
    wrW(8'h74, 32'hCAFE_0001);
    expectRd("R6 unmapped reads zero", 8'h74, 32'h0);
    expectRd("R6 scratch0 untouched", 8'h60, 32'hDEADBEEF);
    expectRd("R6 key at 0x6C not scratch", 8'h6C, 32'h83E70B13);

    // R7 interrupt enable
    wrW(8'h48, 32'h1A5);
    expectRd("R7 word low byte", 8'h48, 32'hA5);
    wrB(8'h48, 8'h3C);
    expectRd("R7 byte lane0", 8'h48, 32'h3C);
    wrB(8'h49, 8'hFF);
    expectRd("R7 lane1 ignored", 8'h48, 32'h3C);
    wrW(8'h48, 32'h0);
    expectRd("R7 clear by zero", 8'h48, 32'h0);

    // R9 write-one-to-clear
    wrW(8'h44, 32'h0);
    expectRd("R9 zero write keeps", 8'h44, 32'hC0);
    wrB(8'h44, 8'h40);
    expectRd("R9 byte clears bit6", 8'h44, 32'h80);
    wrW(8'h44, 32'h80);
    expectRd("R9 word clears bit7", 8'h44, 32'h0);

    // R10 set beats clear
    cyc(0, 8'h00, 0, 0, 1, 1);
    cyc(1, 8'h44, 0, 32'hC0, 1, 0);
    expectRd("R10 alarm held by set", 8'h44, 32'h40);
    cyc(1, 8'h44, 1, 32'hC0, 0, 1);
    expectRd("R10 wake held by set", 8'h44, 32'h80);

    // R3 wrong key relocks, zero relocks
    wrW(8'h70, 32'h95A4F1E1);
    wrW(8'h60, 32'h1111_1111);
    expectRd("R3 wrong key locked", 8'h60, 32'hDEADBEEF);
    unlock();
    wrW(8'h6C, 32'h0);
    wrW(8'h70, 32'h0);
    wrW(8'h64, 32'h2222_2222);
    expectRd("R3 zero relock", 8'h64, 32'h0BADF00D);

    // R11 reads while locked
    expectRd("R11 locked read scratch2", 8'h6A, 32'h13579BDF);
    expectRd("R11 locked read status", 8'h44, 32'h80);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule